// File: doc/BRIEF.md
# Extended Match Timer Bank

This block holds eight additional timer channels, numbered 4 through 11. Each channel has a 32-bit counter, a 32-bit match value and a control word. The control word sets the rate at which the counter advances, whether the counter clears on a match, and whether the channel keeps firing after its first match. Two channels, 5 and 7, can compare against the counter of the channel just below them instead of their own. A snapshot register can capture the count of channel 8 or channel 10 at the moment software reads channel 9 or channel 11.

The rates come from outside the block as single-cycle enable strobes, one for each selectable source. A counter advances by one on each strobe of its selected source. A match on an enabled channel latches a status bit. One interrupt line stays high while any of those status bits is set. Software clears status bits by writing ones to them.

Top module: `xtimer_bank`

## Requirements
- R1: After reset, every counter, match value, control word, status bit, enable bit and the snapshot register reads 0, and `irq` is low.
- R2: The rate select is control bits [2:0]. The value k in 1..5 advances the counter by exactly one in each cycle where `rate_stb[k-1]` is high. The values 0, 6 and 7 hold the counter.
- R3: A bus write to a counter (byte offset 0x40 + 4*(N-4)) loads it in the next cycle, and this load takes priority over advancing. A stopped counter keeps the loaded value.
- R4: With control bit 3 set, a counter that advances onto its channel's match value loads 0 instead.
- R5: A channel matches when the counter it compares against advances onto the match value (offset 0x80 + 4*(N-4)). With control bit 6 set, the channel matches on every such event. With bit 6 clear, it matches once and does not match again until its match value or control word is written.
- R6: Channels 5 and 7 with control bit 7 clear compare against the counter of channel 4 or channel 6 respectively, and their own counter does not advance. With bit 7 set, they use their own counter.
- R7: For channels 8 to 11, control bit 8 set stops the channel's own counter whatever its rate select.
- R8: Control words sit at offset 0xC0 + 4*(N-4). Channels 4 to 7 keep bits [7:0] and read the upper bits as 0. Channels 8 to 11 keep bits [9:0].
- R9: A read of channel 9's counter (0x54) while channel 9's control bit 9 is set copies channel 8's counter into the snapshot register (0x20). A read of channel 11's counter (0x5C) with channel 11's bit 9 set does the same from channel 10. No other access changes the snapshot.
- R10: A match on channel N sets status bit N (register 0x14, bits 11:4) only when enable bit N (register 0x1C, bits 11:4) is set. `irq` is high in each cycle after one in which a status bit is set. Writing a 1 to a status bit clears it. A match in the same cycle as the clear wins.
- R11: Writes to unmapped offsets change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (needed for the snapshot side effect) |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| rate_stb | input | 5 | Rate strobes: 32.768 kHz, 1 kHz, 1 Hz, 1 MHz, external |
| irq | output | 1 | Shared interrupt for channels 4 to 11 |

## Verification
The bound checker watches several things on every cycle. It checks that counter writes land, that a counter with an idle rate select holds, that the snapshot only moves on a qualifying counter read and then takes the neighbour's count, and that the interrupt never rises without an enable bit set. The bench's scenarios cover the rest. They show reset-on-match, one-shot disarm and re-arm, counter linking on channels 5 and 7, the bit-8 stop, the control-word widths, and a match colliding with a status clear. In those scenarios the behavioural model is compared on every clock.

// File: rtl/xtimer_bank.sv
module xtimer_bank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic [4:0]  rate_stb,
  output logic        irq
);
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_IEN  = 8'h1C;
  localparam logic [7:0] A_SNAP = 8'h20;

  logic [7:0][31:0] cnt, mat;
  logic [7:0][9:0]  ctl;
  logic [7:0]       armed, ien, stat;
  logic [31:0]      snap;

  logic [7:0] follow, adv, hit, cwr, mwr, kwr, zero_on;
  logic [2:0] sel;
  logic       tk;

  wire       ch_ok = !addr[5] && addr[1:0] == 2'b00;
  wire [2:0] ch    = addr[4:2];

  always_comb begin
    follow = '0; adv = '0; cwr = '0; mwr = '0; kwr = '0; zero_on = '0;
    for (int i = 0; i < 8; i++) begin
      sel = ctl[i][2:0];
      follow[i] = (i == 1 || i == 3) && !ctl[i][7];
      tk = (sel >= 3'd1 && sel <= 3'd5) ? rate_stb[sel - 3'd1] : 1'b0;
      cwr[i] = wr_en && ch_ok && addr[7:6] == 2'b01 && ch == 3'(i);
      mwr[i] = wr_en && ch_ok && addr[7:6] == 2'b10 && ch == 3'(i);
      kwr[i] = wr_en && ch_ok && addr[7:6] == 2'b11 && ch == 3'(i);
      adv[i] = tk && !follow[i] && !(i >= 4 && ctl[i][8]) && !cwr[i];
      zero_on[i] = ctl[i][3] && (cnt[i] + 32'd1 == mat[i]);
    end
  end

  always_comb begin
    hit = '0;
    for (int i = 0; i < 8; i++) begin
      if (follow[i])
        hit[i] = armed[i] && adv[i-1] && (cnt[i-1] + 32'd1 == mat[i]);
      else
        hit[i] = armed[i] && adv[i] && (cnt[i] + 32'd1 == mat[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; mat <= '0; ctl <= '0;
      armed <= '1; ien <= '0; stat <= '0; snap <= '0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (cwr[i])      cnt[i] <= wdata;
        else if (adv[i]) cnt[i] <= zero_on[i] ? 32'd0 : cnt[i] + 32'd1;
        if (mwr[i]) mat[i] <= wdata;
        if (kwr[i]) ctl[i] <= (i < 4) ? {2'b00, wdata[7:0]} : wdata[9:0];
        if (mwr[i] || kwr[i])           armed[i] <= 1'b1;
        else if (hit[i] && !ctl[i][6]) armed[i] <= 1'b0;
      end
      if (wr_en && addr == A_IEN) ien <= wdata[11:4];
      stat <= (stat & ~((wr_en && addr == A_STAT) ? wdata[11:4] : 8'h00)) | (hit & ien);
      if (rd_en && addr == 8'h54 && ctl[5][9]) snap <= cnt[4];
      else if (rd_en && addr == 8'h5C && ctl[7][9]) snap <= cnt[6];
    end
  end

  always_comb begin
    rdata = '0;
    if (ch_ok && addr[7:6] == 2'b01)      rdata = cnt[ch];
    else if (ch_ok && addr[7:6] == 2'b10) rdata = mat[ch];
    else if (ch_ok && addr[7:6] == 2'b11) rdata = {22'd0, ctl[ch]};
    else if (addr == A_STAT)              rdata = {20'd0, stat, 4'd0};
    else if (addr == A_IEN)               rdata = {20'd0, ien, 4'd0};
    else if (addr == A_SNAP)              rdata = snap;
  end

  assign irq = |stat;
endmodule

module xtimer_bank_chk (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [7:0]       addr,
  input logic [31:0]      wdata,
  input logic             irq,
  input logic [7:0][31:0] cnt,
  input logic [7:0][9:0]  ctl,
  input logic [7:0]       ien,
  input logic [31:0]      snap
);
  for (genvar i = 0; i < 8; i++) begin : g_ch
    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == {2'b01, 1'b0, 3'(i), 2'b00}) |=> cnt[i] == $past(wdata));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && addr == {2'b01, 1'b0, 3'(i), 2'b00}) &&
       (ctl[i][2:0] == 3'd0 || ctl[i][2:0] > 3'd5)) |=> $stable(cnt[i]));
  end

  // R9
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'h54 && ctl[5][9]) |=> snap == $past(cnt[4]));

  // R9
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && (addr == 8'h54 || addr == 8'h5C)) |=> $stable(snap));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ien) != 8'h00);

  // R11
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h60) |=> $stable(ctl) && $stable(ien));
endmodule

bind xtimer_bank xtimer_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .irq(irq), .cnt(cnt), .ctl(ctl), .ien(ien), .snap(snap)
);

// File: tb/sim_xtimer_bank.sv
module sim_xtimer_bank;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [4:0] rate_stb = 0;
  logic irq;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xtimer_bank u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rate_stb(rate_stb), .irq(irq));

  // behavioural reference state
  logic [31:0] m_cnt [8];
  logic [31:0] m_mat [8];
  logic [9:0]  m_ctl [8];
  bit          m_arm [8];
  logic [7:0]  m_ien, m_stat;
  logic [31:0] m_snap;

  function automatic logic [31:0] mread(input logic [7:0] a);
    int c = a[4:2];
    if (a[5] == 0 && a[1:0] == 0) begin
      if (a[7:6] == 1) return m_cnt[c];
      if (a[7:6] == 2) return m_mat[c];
      if (a[7:6] == 3) return {22'd0, m_ctl[c]};
    end
    if (a == 8'h14) return {20'd0, m_stat, 4'd0};
    if (a == 8'h1C) return {20'd0, m_ien, 4'd0};
    if (a == 8'h20) return m_snap;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit fol [8];
    bit stp [8];
    bit go [8];
    bit hit [8];
    logic [7:0] hv, clr;
    logic [31:0] nsnap;
    int s, src;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        m_cnt[i] = 0; m_mat[i] = 0; m_ctl[i] = 0; m_arm[i] = 1;
      end
      m_ien = 0; m_stat = 0; m_snap = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        s = m_ctl[i][2:0];
        fol[i] = (i == 1 || i == 3) && !m_ctl[i][7];
        stp[i] = fol[i] || (i >= 4 && m_ctl[i][8]);
        go[i] = (s >= 1 && s <= 5) && rate_stb[s-1] && !stp[i] &&
                !(wr_en && addr == 8'h40 + 4*i);
      end
      hv = 0;
      for (int i = 0; i < 8; i++) begin
        src = fol[i] ? i - 1 : i;
        hit[i] = m_arm[i] && go[src] && (m_cnt[src] + 1 == m_mat[i]);
        hv[i] = hit[i];
      end
      nsnap = m_snap;
      if (rd_en && addr == 8'h54 && m_ctl[5][9]) nsnap = m_cnt[4];
      else if (rd_en && addr == 8'h5C && m_ctl[7][9]) nsnap = m_cnt[6];
      m_snap = nsnap;
      clr = (wr_en && addr == 8'h14) ? wdata[11:4] : 0;
      m_stat = (m_stat & ~clr) | (hv & m_ien);
      if (wr_en && addr == 8'h1C) m_ien = wdata[11:4];
      for (int i = 0; i < 8; i++) begin
        if (wr_en && addr == 8'h40 + 4*i) m_cnt[i] = wdata;
        else if (go[i])
          m_cnt[i] = (m_ctl[i][3] && m_cnt[i] + 1 == m_mat[i]) ? 0 : m_cnt[i] + 1;
        if (hit[i] && !m_ctl[i][6]) m_arm[i] = 0;
        if (wr_en && (addr == 8'h80 + 4*i || addr == 8'hC0 + 4*i)) m_arm[i] = 1;
        if (wr_en && addr == 8'h80 + 4*i) m_mat[i] = wdata;
        if (wr_en && addr == 8'hC0 + 4*i) m_ctl[i] = (i < 4) ? {2'b0, wdata[7:0]} : wdata[9:0];
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // irq compared against the model every clock (R10)
  always @(negedge clk) if (rst_n && !done) chk("R10 irq", {31'd0, irq}, {31'd0, m_stat != 0});

  task automatic cyc(input bit w, input bit r, input logic [7:0] a,
                     input logic [31:0] d, input logic [4:0] s, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d; rate_stb = s;
    #1;
    if (r) chk(tag, rdata, mread(a));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, "");
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(0, 1, a, 0, 0, tag);
  endtask
  task automatic lit(input logic [7:0] a, input logic [31:0] e, input string tag);
    cyc(0, 1, a, 0, 0, tag);
    chk(tag, rdata, e);
  endtask
  task automatic pulse(input int k, input int n);
    for (int j = 0; j < n; j++) begin
      cyc(0, 0, 0, 0, 5'(1 << k), "");
      cyc(0, 0, 0, 0, 0, "");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    lit(8'h40, 0, "R1 cnt4"); lit(8'hDC, 0, "R1 ctl11");
    lit(8'h14, 0, "R1 stat"); lit(8'h20, 0, "R1 snap");
    chk("R1 irq", {31'd0, irq}, 0);
    // R2 rate selection
    wr(8'hC0, 32'h81);
    pulse(0, 3); pulse(1, 2);
    lit(8'h40, 3, "R2 cnt4 sel1");
    wr(8'hC8, 32'h86);
    for (int k = 0; k < 5; k++) pulse(k, 1);
    lit(8'h48, 0, "R2 cnt6 sel6 holds");
    // R3 load into a stopped counter
    wr(8'h48, 32'h1234);
    pulse(0, 2);
    lit(8'h48, 32'h1234, "R3 cnt6 load");
    // R4 reset on match, periodic, enabled
    wr(8'h1C, 32'hFF0);
    wr(8'h90, 3); wr(8'hD0, 32'hCA);
    pulse(1, 3);
    lit(8'h50, 0, "R4 cnt8 cleared");
    lit(8'h14, 32'h100, "R10 stat8 set");
    wr(8'h14, 32'h100);
    lit(8'h14, 0, "R10 stat8 cleared");
    pulse(1, 3);
    lit(8'h14, 32'h100, "R5 periodic rehit");
    // R10 set wins over clear in the same cycle
    wr(8'h14, 32'hFF0);
    pulse(1, 2);
    cyc(1, 0, 8'h14, 32'h100, 5'b00010, "");
    lit(8'h14, 32'h100, "R10 set beats clear");
    wr(8'h14, 32'hFF0);
    // R5 one-shot
    wr(8'h98, 2); wr(8'hD8, 32'h84);
    pulse(3, 2);
    lit(8'h14, 32'h400, "R5 oneshot hit");
    wr(8'h14, 32'h400); wr(8'h58, 0);
    pulse(3, 3);
    lit(8'h14, 0, "R5 disarmed");
    wr(8'h58, 0); wr(8'h98, 2);
    pulse(3, 2);
    lit(8'h14, 32'h400, "R5 rearmed");
    wr(8'h14, 32'hFF0);
    // R10 disabled channel does not set status
    wr(8'h1C, 32'hBF0);
    wr(8'h58, 0); wr(8'h98, 1); pulse(3, 1);
    lit(8'h14, 0, "R10 enable gates");
    // R6 linking
    wr(8'h44, 32'h77); wr(8'h40, 10); wr(8'h84, 12); wr(8'hC4, 32'h41);
    pulse(0, 2);
    lit(8'h14, 32'h020, "R6 ch5 follows ch4");
    lit(8'h44, 32'h77, "R6 ch5 own held");
    wr(8'h14, 32'hFF0); wr(8'hC4, 32'hC1);
    pulse(0, 2);
    lit(8'h44, 32'h79, "R6 ch5 own runs");
    // R7 bit 8 stop
    wr(8'h54, 5); wr(8'hD4, 32'h181);
    pulse(0, 3);
    lit(8'h54, 5, "R7 ch9 stopped");
    // R8 control widths
    wr(8'hC8, 32'hFFFF_FFFF);
    lit(8'hC8, 32'hFF, "R8 ch6 8 bits");
    wr(8'hC8, 0);
    wr(8'hDC, 32'hFFFF_FFFF);
    lit(8'hDC, 32'h3FF, "R8 ch11 10 bits");
    wr(8'hDC, 0);
    // R9 snapshot
    wr(8'h50, 32'hABCD); wr(8'hD0, 0); wr(8'hD4, 32'h200);
    rd(8'h54, "R9 read ch9");
    lit(8'h20, 32'hABCD, "R9 snapshot ch8");
    wr(8'h50, 32'h5555); wr(8'hD4, 0);
    rd(8'h54, "R9 read ch9 no bit9");
    lit(8'h20, 32'hABCD, "R9 snapshot kept");
    wr(8'h58, 32'h9999); wr(8'hDC, 32'h200);
    rd(8'h5C, "R9 read ch11");
    lit(8'h20, 32'h9999, "R9 snapshot ch10");
    // R11 unmapped
    wr(8'h60, 32'hFFFF_FFFF); wr(8'h00, 32'hFFFF_FFFF);
    lit(8'h60, 0, "R11 unmapped read");
    rd(8'h1C, "R11 ien untouched");
    rd(8'hC0, "R11 ctl4 untouched");
    cyc(0, 0, 0, 0, 0, "");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule